// File: doc/BRIEF.md
# Tagged Byte-Stream Parser with Image Framing

This block takes a byte stream and splits it into messages. Each message opens with a two-byte sync marker. A tag byte follows, then a one-byte length, then that many payload bytes. While the parser hunts for the marker it throws away every byte that does not complete it. The tag sends the payload either to a data output or to a command output. After the last payload byte the parser goes back to hunting.

Command bytes are decoded as image bracketing events. A start-of-image command opens an image and an end-of-image command closes it. Data payload is forwarded only while an image is open. A data message that arrives outside an open image is thrown away and counted. The data output has valid/ready flow control, and the input is stalled whenever a forwarded byte is waiting on the output.

Top module: `tagged_stream_parser`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid`, `cmd_valid`, `img_start`, `img_end` and `img_open` are 0, and `drop_count` is 0.
- R2: The sync marker is the byte 0xA5 followed by the byte 0x5A. Bytes received while hunting produce no output of any kind.
- R3: When the second sync byte is not 0x5A, that byte is checked again as a possible 0xA5 first byte, so A5 A5 5A is a valid marker.
- R4: The tag byte after the marker is 0x00 for a data message and 0x01 for a command message. Any other tag value returns the parser to hunting, and the bytes after it are searched for a new marker.
- R5: The byte after the tag is the payload length (0 to 255). Exactly that many bytes are taken as payload, even if they contain the sync values, and then hunting resumes. A length of 0 produces no payload output.
- R6: Each command payload byte appears on `cmd_byte` with a one-cycle `cmd_valid` pulse in the cycle after it is accepted.
- R7: Command byte 0x10 sets `img_open` and pulses `img_start`, even when an image is already open. Command byte 0x11 clears `img_open` and pulses `img_end`, but only if an image is open. Other command bytes do not change the image state.
- R8: Data payload bytes are forwarded in order on `out_data` while `img_open` is 1. When a data tag is accepted while no image is open, the whole message is discarded and `drop_count` goes up by one.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Incoming stream byte |
| in_valid | input | 1 | `in_data` is present |
| in_ready | output | 1 | Parser accepts the byte this cycle |
| out_data | output | 8 | Forwarded image data byte |
| out_valid | output | 1 | `out_data` is present |
| out_ready | input | 1 | Downstream takes `out_data` |
| cmd_byte | output | 8 | Command payload byte |
| cmd_valid | output | 1 | One-cycle pulse marking `cmd_byte` |
| img_start | output | 1 | Pulse when an image is opened |
| img_end | output | 1 | Pulse when an image is closed |
| img_open | output | 1 | An image is currently open |
| drop_count | output | DROP_W | Number of discarded data messages |

## Verification
The bench targets these cases:
- A partial marker followed by a repeated 0xA5. A parser that restarts without rechecking the failing byte loses the message that follows.
- An illegal tag. A parser that wrongly advances on it forwards garbage.
- A zero length. A parser that wrongly handles it swallows the next marker as payload.
- Payload bytes that contain the marker values. A parser that resynchronises inside the payload splits the message.
- End-of-image while closed, a repeated start, and data outside an image. Wrong handling shows as extra pulses, missing bytes or a wrong drop count.
- Random stalls on `out_ready`. These expose bytes that change or get lost under backpressure.

// File: rtl/tagged_stream_parser.sv
module tagged_stream_parser #(
  parameter logic [7:0] SYNC_HI = 8'hA5,
  parameter logic [7:0] SYNC_LO = 8'h5A,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        cmd_byte,
  output logic              cmd_valid,
  output logic              img_start,
  output logic              img_end,
  output logic              img_open,
  output logic [DROP_W-1:0] drop_count
);

  localparam logic [7:0] TAG_DATA = 8'h00;
  localparam logic [7:0] TAG_CMD  = 8'h01;
  localparam logic [7:0] CMD_SOI  = 8'h10;
  localparam logic [7:0] CMD_EOI  = 8'h11;

  typedef enum logic [2:0] {HUNT_A, HUNT_B, GET_TAG, GET_LEN, PAYLOAD} st_t;

  st_t        st;
  logic       is_cmd;
  logic [7:0] left;
  logic       take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= HUNT_A;
      is_cmd     <= 1'b0;
      left       <= '0;
      out_data   <= '0;
      out_valid  <= 1'b0;
      cmd_byte   <= '0;
      cmd_valid  <= 1'b0;
      img_start  <= 1'b0;
      img_end    <= 1'b0;
      img_open   <= 1'b0;
      drop_count <= '0;
    end else begin
      cmd_valid <= 1'b0;
      img_start <= 1'b0;
      img_end   <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        case (st)
          HUNT_A: if (in_data == SYNC_HI) st <= HUNT_B;
          HUNT_B: begin
            if (in_data == SYNC_LO)      st <= GET_TAG;
            else if (in_data != SYNC_HI) st <= HUNT_A;
          end
          GET_TAG: begin
            if (in_data == TAG_DATA) begin
              is_cmd <= 1'b0;
              st     <= GET_LEN;
              if (!img_open) drop_count <= drop_count + 1'b1;
            end else if (in_data == TAG_CMD) begin
              is_cmd <= 1'b1;
              st     <= GET_LEN;
            end else begin
              st <= HUNT_A;
            end
          end
          GET_LEN: begin
            left <= in_data;
            if (in_data == 8'd0) st <= HUNT_A;
            else                 st <= PAYLOAD;
          end
          PAYLOAD: begin
            left <= left - 8'd1;
            if (left == 8'd1) st <= HUNT_A;
            if (is_cmd) begin
              cmd_valid <= 1'b1;
              cmd_byte  <= in_data;
              if (in_data == CMD_SOI) begin
                img_open  <= 1'b1;
                img_start <= 1'b1;
              end else if (in_data == CMD_EOI && img_open) begin
                img_open <= 1'b0;
                img_end  <= 1'b1;
              end
            end else if (img_open) begin
              out_valid <= 1'b1;
              out_data  <= in_data;
            end
          end
          default: st <= HUNT_A;
        endcase
      end
    end
  end

  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r9_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r7_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    img_start |-> img_open);

  a_r7_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
    img_end |-> !img_open);

  a_r7_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({img_start, img_end}));

  a_r8_forward_only_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> img_open);

endmodule

// File: tb/test_tagged_stream_parser.sv
module test_tagged_stream_parser;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  in_data = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 0;
  logic [7:0]  cmd_byte;
  logic        cmd_valid;
  logic        img_start, img_end, img_open;
  logic [15:0] drop_count;

  tagged_stream_parser i_tagged_stream_parser (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .cmd_byte(cmd_byte), .cmd_valid(cmd_valid), .img_start(img_start), .img_end(img_end),
    .img_open(img_open), .drop_count(drop_count));

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  string tag = "R2";
  logic [7:0] stream[$];
  logic [7:0] exp_data[$];
  logic [7:0] exp_cmd[$];
  int m_state = 0, m_left = 0, m_cmd = 0, m_open = 0;
  int m_drop = 0, m_starts = 0, m_ends = 0, seen_starts = 0, seen_ends = 0;
  logic       prev_hold = 0;
  logic [7:0] prev_data = 0;
  logic       out_rand = 1;

  task automatic check(input string req, input logic ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model of the requirements, fed one byte at a time
  task automatic put(input logic [7:0] b);
    stream.push_back(b);
    case (m_state)
      0: if (b == 8'hA5) m_state = 1;
      1: if (b == 8'h5A) m_state = 2; else if (b != 8'hA5) m_state = 0;
      2: if (b == 8'h00) begin m_cmd = 0; m_state = 3; if (m_open == 0) m_drop++; end
         else if (b == 8'h01) begin m_cmd = 1; m_state = 3; end
         else m_state = 0;
      3: begin m_left = b; m_state = (b == 0) ? 0 : 4; end
      default: begin
        m_left--;
        if (m_left == 0) m_state = 0;
        if (m_cmd == 1) begin
          exp_cmd.push_back(b);
          if (b == 8'h10) begin m_open = 1; m_starts++; end
          else if (b == 8'h11 && m_open == 1) begin m_open = 0; m_ends++; end
        end else if (m_open == 1) exp_data.push_back(b);
      end
    endcase
  endtask

  task automatic msg(input logic [7:0] t, input int len, input logic [7:0] first);
    put(8'hA5); put(8'h5A); put(t); put(len[7:0]);
    for (int i = 0; i < len; i++) put(i == 0 ? first : 8'($urandom));
  endtask

  task automatic send_all();
    while (stream.size() > 0) begin
      logic got;
      @(negedge clk);
      if ($urandom % 6 == 0) begin in_valid = 0; continue; end
      in_valid = 1;
      in_data = stream.pop_front();
      forever begin
        got = in_ready;
        @(posedge clk);
        if (got) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 0;
    repeat (40) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1 out_ready <= out_rand ? ($urandom % 3 != 0) : 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold) check("R9 hold", out_valid && out_data == prev_data, out_data, prev_data);
      if (out_valid && !out_ready) check("R9 stall", !in_ready, in_ready, 0);
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (out_valid && out_ready) begin
        if (exp_data.size() == 0) check({tag, " unexpected data"}, 0, out_data, 0);
        else begin
          logic [7:0] e;
          e = exp_data.pop_front();
          check({tag, " R8 data"}, out_data == e, out_data, e);
        end
      end
      if (cmd_valid) begin
        if (exp_cmd.size() == 0) check("R6 unexpected cmd", 0, cmd_byte, 0);
        else begin
          logic [7:0] e;
          e = exp_cmd.pop_front();
          check("R6 cmd", cmd_byte == e, cmd_byte, e);
        end
      end
      if (img_start) seen_starts++;
      if (img_end) seen_ends++;
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check("watchdog", 0, cyc, 0);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1 in_ready", in_ready == 1, in_ready, 1);
    check("R1 out_valid", out_valid == 0, out_valid, 0);
    check("R1 cmd_valid", cmd_valid == 0, cmd_valid, 0);
    check("R1 img", {img_start, img_end, img_open} == 0, {img_start, img_end, img_open}, 0);
    check("R1 drop_count", drop_count == 0, drop_count, 0);
    rst_n = 1;

    // R2: junk while hunting, then open image and send data
    tag = "R2";
    put(8'h11); put(8'h22); put(8'hA5); put(8'h33); put(8'h5A);
    msg(8'h01, 1, 8'h10);
    msg(8'h00, 3, 8'h01);
    send_all();
    check("R2 data drained", exp_data.size() == 0, exp_data.size(), 0);

    // R3: failing partial match rechecked
    tag = "R3";
    put(8'hA5); msg(8'h00, 2, 8'h44);
    put(8'hA5); put(8'hA5); msg(8'h00, 1, 8'h66);
    put(8'h5A); msg(8'h00, 1, 8'h77);
    send_all();
    check("R3 data drained", exp_data.size() == 0, exp_data.size(), 0);

    // R4: illegal tags return to hunting
    tag = "R4";
    put(8'hA5); put(8'h5A); put(8'h07); put(8'h02); put(8'h55);
    msg(8'h00, 1, 8'h88);
    put(8'hA5); put(8'h5A); put(8'hFF); msg(8'h00, 2, 8'h99);
    send_all();
    check("R4 data drained", exp_data.size() == 0, exp_data.size(), 0);

    // R5: zero length, payload containing sync values
    tag = "R5";
    msg(8'h00, 0, 8'h00);
    msg(8'h01, 0, 8'h00);
    put(8'hA5); put(8'h5A); put(8'h00); put(8'h03); put(8'hA5); put(8'h5A); put(8'h00);
    msg(8'h00, 1, 8'h3C);
    send_all();
    check("R5 data drained", exp_data.size() == 0, exp_data.size(), 0);

    // R7/R8: close, drop data, end while closed, restart twice
    tag = "R8";
    msg(8'h01, 1, 8'h11);
    msg(8'h00, 4, 8'h12);
    msg(8'h01, 2, 8'h11);
    msg(8'h00, 0, 8'h00);
    msg(8'h01, 2, 8'h10);
    msg(8'h00, 2, 8'h21);
    send_all();
    check("R8 drop_count directed", drop_count == 16'(m_drop), drop_count, m_drop);
    check("R7 img_open directed", img_open == m_open[0], img_open, m_open);

    // R9 under full stall, then random traffic
    tag = "R9";
    out_rand = 0;
    msg(8'h00, 3, 8'h31);
    fork send_all(); join_none
    repeat (20) @(negedge clk);
    check("R9 stalled", out_valid == 1 && in_ready == 0, {out_valid, in_ready}, 2);
    out_rand = 1;
    repeat (60) @(negedge clk);

    tag = "R8";
    for (int k = 0; k < 300; k++) begin
      int r;
      r = $urandom % 10;
      if (r < 2) put(8'($urandom));
      else if (r < 5) msg(8'h01, 1 + $urandom % 2, ($urandom % 2) ? 8'h10 : 8'h11);
      else if (r < 9) msg(8'h00, $urandom % 7, 8'($urandom));
      else begin put(8'hA5); put(8'h5A); put(8'h02 + 8'($urandom % 200)); end
    end
    send_all();
    check("R8 data drained", exp_data.size() == 0, exp_data.size(), 0);
    check("R6 cmd drained", exp_cmd.size() == 0, exp_cmd.size(), 0);
    check("R8 drop_count", drop_count == 16'(m_drop), drop_count, m_drop);
    check("R7 starts", seen_starts == m_starts, seen_starts, m_starts);
    check("R7 ends", seen_ends == m_ends, seen_ends, m_ends);
    check("R7 img_open", img_open == m_open[0], img_open, m_open);
    finish_run();
  end
endmodule